// File: doc/BRIEF.md
# Arithmetic Exception Result Fixup Unit

This unit sits after the rounding stage of an extended-precision arithmetic datapath. Each result arrives with an unbounded signed biased exponent, a 64-bit significand with explicit integer bit, a sign and a code naming which range or divide condition was detected. The unit also receives the three exception mask bits that matter to it. When the condition is masked, it substitutes the default result: a signed infinity, a signed zero, or the unchanged value for later denormal formatting. When the condition is unmasked, it moves the exponent by a fixed trap bias so that a trap handler sees a representable number.

Alongside the fixed-up value, the unit produces a 2-bit result tag, the exception flags to raise in the status unit and a request to set or clear the C1 condition bit. The stage is one register deep. It has a valid/ready pair on each side and holds its output until that output is accepted.

The condition code is 00 for none, 01 for overflow, 10 for underflow and 11 for zero-divide. The mask input uses bit 0 for zero-divide, bit 1 for overflow and bit 2 for underflow; a 1 means masked. The exception request bits are [0] zero-divide, [1] overflow, [2] underflow and [3] precision. The tag is 00 for valid, 01 for zero, 10 for special and 11 for empty. The exponent carries a bias of 16383, infinity uses exponent 32767 with significand 0x8000000000000000, and the trap bias is 24576.

Top module: `exc_fixup`

## Requirements
- R1: With condition 00, the result passes through unchanged with tag 00, no exception request and no C1 request.
- R2: A masked zero-divide outputs infinity (exponent 32767, significand 0x8000000000000000) with the supplied sign, tag 10, and only exception bit 0 set.
- R3: An unmasked zero-divide leaves sign, exponent and significand unchanged, gives tag 00 and sets only exception bit 0.
- R4: A masked overflow outputs infinity with the supplied sign and tag 10, sets exception bits 1 and 3, and requests C1 set.
- R5: An unmasked overflow subtracts 24576 from the exponent, keeps sign and significand, gives tag 00, sets only exception bit 1 and makes no C1 request.
- R6: A masked underflow with exponent at or below -62 outputs exponent 0, significand 0 and the supplied sign, with tag 01. It sets exception bits 2 and 3 and requests C1 clear.
- R7: A masked underflow with exponent above -62 passes the value unchanged with tag 00, sets exception bits 2 and 3, and requests C1 clear.
- R8: An unmasked underflow adds 40959 (24576 plus the bias 16383) to the exponent, gives tag 00 and sets only exception bit 2.
- R9: Only the mask bit that belongs to the reported condition affects the result; the other mask bits are ignored.
- R10: An accepted input appears at the output one clock later. While the output is valid and not accepted, it holds stable, `in_ready` is low and any offered input is not taken.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input result offered |
| in_ready | output | 1 | Stage can take an input |
| in_cond | input | 2 | Condition code: 00 none, 01 overflow, 10 underflow, 11 zero-divide |
| in_mask | input | 3 | Mask bits: [0] zero-divide, [1] overflow, [2] underflow |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | EXP_W | Unbounded signed biased exponent |
| in_sig | input | SIG_W | Significand with explicit integer bit |
| out_valid | output | 1 | Fixed-up result present |
| out_ready | input | 1 | Consumer accepts the output |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent |
| out_sig | output | SIG_W | Result significand |
| out_tag | output | 2 | 00 valid, 01 zero, 10 special, 11 empty |
| out_exc | output | 4 | Exception requests: [0] zero-divide, [1] overflow, [2] underflow, [3] precision |
| out_c1_set | output | 1 | Request to set C1 |
| out_c1_clr | output | 1 | Request to clear C1 |

## Verification
The table covers every condition code with its own mask both set and clear. This separates default substitution from trap rebiasing, and it shows that each path raises the right flags and C1 request. Underflow is tried at exponents -62 and -61 to pin the flush boundary, and far below it to confirm the flush. Overflow and zero-divide are tried with both signs so that the infinity sign follows the input. Rows that set the unrelated mask bits show that those bits have no effect. Directed sequences stall the consumer to confirm that the output is held and that an offered input is refused.

// File: rtl/fx_pkg.sv
package fx_pkg;
  typedef enum logic [1:0] {
    COND_NONE = 2'b00,
    COND_OVF  = 2'b01,
    COND_UNF  = 2'b10,
    COND_ZDIV = 2'b11
  } cond_e;

  typedef enum logic [2:0] {
    ACT_PASS = 3'd0,
    ACT_INF  = 3'd1,
    ACT_ZERO = 3'd2,
    ACT_SUB  = 3'd3,
    ACT_ADD  = 3'd4
  } act_e;

  localparam logic [1:0] TAG_VALID   = 2'b00;
  localparam logic [1:0] TAG_ZERO    = 2'b01;
  localparam logic [1:0] TAG_SPECIAL = 2'b10;
  localparam logic [1:0] TAG_EMPTY   = 2'b11;

  localparam int MSK_ZDIV = 0;
  localparam int MSK_OVF  = 1;
  localparam int MSK_UNF  = 2;

  localparam int EXC_ZDIV = 0;
  localparam int EXC_OVF  = 1;
  localparam int EXC_UNF  = 2;
  localparam int EXC_PREC = 3;
  localparam int EXC_W    = 4;
endpackage

// File: rtl/fx_classify.sv
module fx_classify
  import fx_pkg::*;
#(
  parameter int EXP_W       = 20,
  parameter int DENORM_SPAN = 63
) (
  input  logic [1:0]              cond,
  input  logic [2:0]              mask,
  input  logic signed [EXP_W-1:0] exp_in,
  output act_e                    act,
  output logic [EXC_W-1:0]        exc,
  output logic                    c1_set,
  output logic                    c1_clr
);
  // Lowest normal biased exponent is 1; values this far below it flush to zero.
  localparam logic signed [EXP_W-1:0] FLUSH_LIM = EXP_W'(1 - DENORM_SPAN);

  logic flush;
  assign flush = (exp_in <= FLUSH_LIM);

  always_comb begin
    act    = ACT_PASS;
    exc    = '0;
    c1_set = 1'b0;
    c1_clr = 1'b0;
    case (cond_e'(cond))
      COND_OVF: begin
        exc[EXC_OVF] = 1'b1;
        if (mask[MSK_OVF]) begin
          act           = ACT_INF;
          exc[EXC_PREC] = 1'b1;
          c1_set        = 1'b1;
        end else begin
          act = ACT_SUB;
        end
      end
      COND_UNF: begin
        exc[EXC_UNF] = 1'b1;
        if (mask[MSK_UNF]) begin
          exc[EXC_PREC] = 1'b1;
          c1_clr        = 1'b1;
          act           = flush ? ACT_ZERO : ACT_PASS;
        end else begin
          act = ACT_ADD;
        end
      end
      COND_ZDIV: begin
        exc[EXC_ZDIV] = 1'b1;
        act           = mask[MSK_ZDIV] ? ACT_INF : ACT_PASS;
      end
      default: act = ACT_PASS;
    endcase
  end
endmodule

// File: rtl/fx_datapath.sv
module fx_datapath
  import fx_pkg::*;
#(
  parameter int EXP_W     = 20,
  parameter int SIG_W     = 64,
  parameter int EXP_BIAS  = 16383,
  parameter int TRAP_BIAS = 24576
) (
  input  act_e                    act,
  input  logic                    sign_in,
  input  logic signed [EXP_W-1:0] exp_in,
  input  logic [SIG_W-1:0]        sig_in,
  output logic                    sign_out,
  output logic signed [EXP_W-1:0] exp_out,
  output logic [SIG_W-1:0]        sig_out,
  output logic [1:0]              tag_out
);
  localparam logic signed [EXP_W-1:0] INF_EXP = EXP_W'(2 * EXP_BIAS + 1);
  localparam logic signed [EXP_W-1:0] DN_ADJ  = EXP_W'(TRAP_BIAS);
  localparam logic signed [EXP_W-1:0] UP_ADJ  = EXP_W'(TRAP_BIAS + EXP_BIAS);
  localparam logic [SIG_W-1:0]        INF_SIG = {1'b1, {(SIG_W-1){1'b0}}};

  always_comb begin
    sign_out = sign_in;
    exp_out  = exp_in;
    sig_out  = sig_in;
    tag_out  = TAG_VALID;
    case (act)
      ACT_INF: begin
        exp_out = INF_EXP;
        sig_out = INF_SIG;
        tag_out = TAG_SPECIAL;
      end
      ACT_ZERO: begin
        exp_out = '0;
        sig_out = '0;
        tag_out = TAG_ZERO;
      end
      ACT_SUB: exp_out = exp_in - DN_ADJ;
      ACT_ADD: exp_out = exp_in + UP_ADJ;
      default: ;
    endcase
  end
endmodule

// File: rtl/fx_hold.sv
module fx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end

  // R10: a stalled result stays put until taken
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R10: no input is taken while the output is stalled
  assert_no_take_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: rtl/exc_fixup.sv
module exc_fixup
  import fx_pkg::*;
#(
  parameter int EXP_W       = 20,
  parameter int SIG_W       = 64,
  parameter int EXP_BIAS    = 16383,
  parameter int TRAP_BIAS   = 24576,
  parameter int DENORM_SPAN = 63
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              in_cond,
  input  logic [2:0]              in_mask,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0]        in_sig,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_sign,
  output logic signed [EXP_W-1:0] out_exp,
  output logic [SIG_W-1:0]        out_sig,
  output logic [1:0]              out_tag,
  output logic [3:0]              out_exc,
  output logic                    out_c1_set,
  output logic                    out_c1_clr
);
  localparam int HOLD_W = 1 + EXP_W + SIG_W + 2 + EXC_W + 2;
  localparam logic signed [EXP_W-1:0] INF_EXP = EXP_W'(2 * EXP_BIAS + 1);
  localparam logic [SIG_W-1:0]        INF_SIG = {1'b1, {(SIG_W-1){1'b0}}};

  act_e                    act;
  logic [EXC_W-1:0]        exc_c;
  logic                    c1s_c, c1c_c;
  logic                    sign_c;
  logic signed [EXP_W-1:0] exp_c;
  logic [SIG_W-1:0]        sig_c;
  logic [1:0]              tag_c;
  logic [HOLD_W-1:0]       pack_in, pack_out;

  fx_classify #(.EXP_W(EXP_W), .DENORM_SPAN(DENORM_SPAN)) u_cls (
    .cond(in_cond), .mask(in_mask), .exp_in(in_exp),
    .act(act), .exc(exc_c), .c1_set(c1s_c), .c1_clr(c1c_c)
  );

  fx_datapath #(.EXP_W(EXP_W), .SIG_W(SIG_W), .EXP_BIAS(EXP_BIAS),
                .TRAP_BIAS(TRAP_BIAS)) u_dp (
    .act(act), .sign_in(in_sign), .exp_in(in_exp), .sig_in(in_sig),
    .sign_out(sign_c), .exp_out(exp_c), .sig_out(sig_c), .tag_out(tag_c)
  );

  assign pack_in = {sign_c, exp_c, sig_c, tag_c, exc_c, c1s_c, c1c_c};

  fx_hold #(.W(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(pack_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(pack_out)
  );

  assign {out_sign, out_exp, out_sig, out_tag, out_exc, out_c1_set, out_c1_clr} = pack_out;

  // R1: the empty tag is never produced
  assert_tag_legal_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_tag != TAG_EMPTY);
  // R9: at most one primary cause per result
  assert_one_cause_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(out_exc[2:0]));
  // R4: a precision-chained overflow rounds up to infinity
  assert_ovf_c1_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_exc[EXC_OVF] && out_exc[EXC_PREC] |-> out_c1_set && out_tag == TAG_SPECIAL);
  // R6: a precision-chained underflow rounds down
  assert_unf_c1_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_exc[EXC_UNF] && out_exc[EXC_PREC] |-> out_c1_clr && !out_c1_set);
  // R2: a special result is always the infinity encoding
  assert_special_inf_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_tag == TAG_SPECIAL |-> out_exp == INF_EXP && out_sig == INF_SIG);
  // R6: a zero tag carries a zero significand and exponent
  assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_tag == TAG_ZERO |-> out_sig == '0 && out_exp == '0);
endmodule

// File: tb/sim_exc_fixup.sv
module sim_exc_fixup;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 20;
  localparam int SW = 64;
  localparam logic [SW-1:0] S1  = 64'hC000_0000_0000_1234;
  localparam logic [SW-1:0] INF = 64'h8000_0000_0000_0000;

  typedef struct packed {
    logic [3:0]    req;
    logic [1:0]    cond;
    logic [2:0]    mask;
    logic          sign;
    logic [EW-1:0] exp;
    logic [SW-1:0] sig;
    logic          e_sign;
    logic [EW-1:0] e_exp;
    logic [SW-1:0] e_sig;
    logic [1:0]    e_tag;
    logic [3:0]    e_exc;
    logic          e_c1s;
    logic          e_c1c;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 2'b00, 3'b000, 1'b0, 20'd16383, S1, 1'b0, 20'd16383, S1, 2'b00, 4'b0000, 1'b0, 1'b0},   // R1
    '{4'd2, 2'b11, 3'b001, 1'b1, 20'd100, S1, 1'b1, 20'd32767, INF, 2'b10, 4'b0001, 1'b0, 1'b0},     // R2
    '{4'd2, 2'b11, 3'b111, 1'b0, 20'd100, S1, 1'b0, 20'd32767, INF, 2'b10, 4'b0001, 1'b0, 1'b0},     // R2
    '{4'd3, 2'b11, 3'b110, 1'b1, 20'd100, S1, 1'b1, 20'd100, S1, 2'b00, 4'b0001, 1'b0, 1'b0},        // R3, R9
    '{4'd4, 2'b01, 3'b010, 1'b0, 20'd40000, S1, 1'b0, 20'd32767, INF, 2'b10, 4'b1010, 1'b1, 1'b0},   // R4
    '{4'd4, 2'b01, 3'b010, 1'b1, 20'd33000, S1, 1'b1, 20'd32767, INF, 2'b10, 4'b1010, 1'b1, 1'b0},   // R4
    '{4'd5, 2'b01, 3'b101, 1'b0, 20'd40000, S1, 1'b0, 20'd15424, S1, 2'b00, 4'b0010, 1'b0, 1'b0},    // R5, R9
    '{4'd6, 2'b10, 3'b100, 1'b1, 20'(-62), S1, 1'b1, 20'd0, 64'd0, 2'b01, 4'b1100, 1'b0, 1'b1},      // R6 boundary
    '{4'd7, 2'b10, 3'b100, 1'b1, 20'(-61), S1, 1'b1, 20'(-61), S1, 2'b00, 4'b1100, 1'b0, 1'b1},      // R7 boundary
    '{4'd6, 2'b10, 3'b111, 1'b0, 20'(-5000), S1, 1'b0, 20'd0, 64'd0, 2'b01, 4'b1100, 1'b0, 1'b1},    // R6
    '{4'd8, 2'b10, 3'b011, 1'b0, 20'(-62), S1, 1'b0, 20'd40897, S1, 2'b00, 4'b0100, 1'b0, 1'b0},     // R8, R9
    '{4'd8, 2'b10, 3'b000, 1'b1, 20'd0, S1, 1'b1, 20'd40959, S1, 2'b00, 4'b0100, 1'b0, 1'b0},        // R8
    '{4'd9, 2'b00, 3'b111, 1'b1, 20'(-10), S1, 1'b1, 20'(-10), S1, 2'b00, 4'b0000, 1'b0, 1'b0}       // R9, R1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [1:0] in_cond = '0;
  logic [2:0] in_mask = '0;
  logic in_sign = 1'b0;
  logic signed [EW-1:0] in_exp = '0;
  logic [SW-1:0] in_sig = '0;
  logic out_sign, out_c1_set, out_c1_clr;
  logic signed [EW-1:0] out_exp;
  logic [SW-1:0] out_sig;
  logic [1:0] out_tag;
  logic [3:0] out_exc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_fixup u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cond(in_cond), .in_mask(in_mask), .in_sign(in_sign), .in_exp(in_exp),
    .in_sig(in_sig), .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig), .out_tag(out_tag),
    .out_exc(out_exc), .out_c1_set(out_c1_set), .out_c1_clr(out_c1_clr)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic logic [SW+EW+9:0] outvec();
    return {out_sign, out_exp, out_sig, out_tag, out_exc, out_c1_set, out_c1_clr};
  endfunction

  task automatic drive(input vec_t v);
    in_cond = v.cond; in_mask = v.mask; in_sign = v.sign;
    in_exp = v.exp; in_sig = v.sig;
  endtask

  initial begin
    vec_t hv;
    logic [SW+EW+9:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 out_valid after reset", 128'(out_valid), 128'(0));
    check("R11 in_ready after reset", 128'(in_ready), 128'(1));

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vec %0d valid", VECS[i].req, i), 128'(out_valid), 128'(1));
      check($sformatf("R%0d vec %0d result", VECS[i].req, i), 128'(outvec()),
            128'({VECS[i].e_sign, VECS[i].e_exp, VECS[i].e_sig, VECS[i].e_tag,
                  VECS[i].e_exc, VECS[i].e_c1s, VECS[i].e_c1c}));
    end
    @(negedge clk);
    check("R10 output drains when accepted", 128'(out_valid), 128'(0));

    // R10: stall the consumer, offer a second input, confirm it is refused
    out_ready = 1'b0;
    drive(VECS[4]);
    in_valid = 1'b1;
    @(negedge clk);
    held = outvec();
    hv = VECS[4];
    check("R10 stalled output valid", 128'(out_valid), 128'(1));
    check("R10 in_ready low while stalled", 128'(in_ready), 128'(0));
    check("R10 first result", 128'(held),
          128'({hv.e_sign, hv.e_exp, hv.e_sig, hv.e_tag, hv.e_exc, hv.e_c1s, hv.e_c1c}));
    drive(VECS[10]);
    repeat (2) @(negedge clk);
    check("R10 held while stalled", 128'(outvec()), 128'(held));
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R10 refused input not taken", 128'(out_valid), 128'(0));

    // R10: back-to-back accepted inputs stream one per clock
    drive(VECS[0]); in_valid = 1'b1;
    @(negedge clk);
    drive(VECS[11]);
    check("R10 stream first", 128'(out_exp), 128'(VECS[0].e_exp));
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 stream second", 128'(out_exp), 128'(VECS[11].e_exp));

    // R11: reset clears a pending result
    out_ready = 1'b0; drive(VECS[1]); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R11 reset clears valid", 128'(out_valid), 128'(0));
    rst = 1'b0; out_ready = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule